// File: doc/BRIEF.md
# Page Table Entry Walker

This block turns a 32-bit virtual address into a physical address by reading one page table entry from external memory. Pages are 4096 bytes: the high 20 bits of the address select the entry and the low 12 bits pass through unchanged as the offset. The table is flat, with one 4-byte entry per virtual page. The entry for a page sits at the table base plus four times the virtual page number. Software loads the base into a register inside the block.

A request carries a virtual address, a store flag and an instruction-fetch flag. The block accepts it with a valid/ready handshake and reads the entry. It then checks the entry's valid bit and its two protection bits, and it answers with either the physical address or a fault code. After a legal access it sets the entry's referenced bit, and also its modified bit on a store. The entry goes back to memory only when one of those bits actually changed.

The memory port holds its request until it is acknowledged. Read data is taken in the same cycle as the acknowledge. Only one translation is in flight at a time.

Top module: `pte_walker`

## Requirements
- R1: A successful translation returns the entry's 20-bit frame number (entry bits 31:12) concatenated with the unchanged 12-bit offset, with fault code 00; for example, virtual 0x13325328 with frame 0x03004 gives 0x03004328.
- R2: The entry is read from address base + (virtual page number × 4). The memory request, address and write flag stay stable until memAck.
- R3: When entry bit 0 (valid) is clear, the response carries fault code 01 (absent) and nothing is written back.
- R4: A store to a page whose protection field (entry bits 4:3) is 00 or 01 (read-only) gives fault code 10 (protection) and no write-back.
- R5: An instruction fetch is allowed only when the protection field is 11. Any other value gives fault code 10.
- R6: Protection 00 denies every access, including plain reads, with fault code 10.
- R7: A successful access sets entry bit 1 (referenced), and a successful store also sets bit 2 (modified). The write-back keeps every other entry bit unchanged.
- R8: The entry is written back only when the referenced or modified bit changes. An access that finds them already set performs no memory write.
- R9: reqReady is high only when no translation is in flight. rspValid is a single-cycle pulse.
- R10: With a memory that acknowledges one cycle after a request, rspValid rises 3 clock edges after the accepting edge when nothing is written back, and 5 edges after it when the entry is written back.
- R11: The table base resets to 0 and is loaded from ptBaseIn when ptBaseWe is high. Each request uses the base value held at the edge that accepts it.
- R12: A faulting response drives rspPaddr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptBaseWe | input | 1 | Load strobe for the table base |
| ptBaseIn | input | 32 | New table base value |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a store |
| reqFetch | input | 1 | Access is an instruction fetch |
| rspValid | output | 1 | Response pulse |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspFault | output | 2 | 00 ok, 01 absent, 10 protection |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Entry address |
| memWdata | output | 32 | Updated entry for write-back |
| memAck | input | 1 | Memory access done |
| memRdata | input | 32 | Entry read data, valid with memAck |

## Verification
The memory model in the bench acknowledges each request one cycle after it sees it. Under that model a response is due 3 edges after the accepting edge when no write-back is needed, and 5 edges after it when the entry is rewritten. The bench records the cycle count at the falling edge after acceptance. When rspValid appears at a falling edge, it compares the elapsed count with the value expected from the bench's own prediction of whether a write-back occurs. The same sample also checks the entry address the model served and the number of memory writes since the previous response. A final pass compares the memory contents with the bench's shadow table.

// File: rtl/pte_walk_pkg.sv
package pte_walk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    PR_NONE = 2'b00,
    PR_RO   = 2'b01,
    PR_RW   = 2'b10,
    PR_RWX  = 2'b11
  } prot_e;

  // entry bit positions below the frame number
  localparam int VLD_BIT  = 0;
  localparam int REF_BIT  = 1;
  localparam int MOD_BIT  = 2;
  localparam int PROT_LSB = 3;

  typedef struct packed {
    logic takeReq;
    logic takeEntry;
    logic takeResult;
    logic busRd;
    logic busWr;
    logic rspOut;
  } strobe_t;

endpackage

// File: rtl/pte_walk_ctrl.sv
module pte_walk_ctrl
  import pte_walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memAck,
  input  logic    chkFault,
  input  logic    chkWb,
  output logic    reqReady,
  output strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_STORE, ST_REPLY
  } state_e;

  state_e stQ, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  always_comb begin
    stNext = stQ;
    case (stQ)
      ST_IDLE:  if (reqValid) stNext = ST_FETCH;
      ST_FETCH: if (memAck)   stNext = ST_CHECK;
      ST_CHECK: stNext = (!chkFault && chkWb) ? ST_STORE : ST_REPLY;
      ST_STORE: if (memAck)   stNext = ST_REPLY;
      ST_REPLY: stNext = ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.takeReq    = (stQ == ST_IDLE) && reqValid;
    stb.takeEntry  = (stQ == ST_FETCH) && memAck;
    stb.takeResult = (stQ == ST_CHECK);
    stb.busRd      = (stQ == ST_FETCH);
    stb.busWr      = (stQ == ST_STORE);
    stb.rspOut     = (stQ == ST_REPLY);
  end

  assign reqReady = (stQ == ST_IDLE);

endmodule

// File: rtl/pte_walk_datapath.sv
module pte_walk_datapath
  import pte_walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              ptBaseWe,
  input  logic [ADDR_W-1:0] ptBaseIn,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] entryAddr,
  output logic [ADDR_W-1:0] newEntry,
  output logic              chkFault,
  output logic              chkWb,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [1:0]        rspFault
);

  localparam int VPN_W       = ADDR_W - PAGE_BITS;
  localparam int ENTRY_SHIFT = $clog2(PTE_BYTES);

  logic [ADDR_W-1:0]    baseQ;
  logic [ADDR_W-1:0]    addrQ;
  logic [PAGE_BITS-1:0] offQ;
  logic                 isWrQ, isExQ;
  logic [ADDR_W-1:0]    entryQ;
  fault_e               faultQ;
  logic [ADDR_W-1:0]    paddrQ;

  logic [VPN_W-1:0]     vpnIn;
  logic [ADDR_W-1:0]    vpnScaled;
  prot_e                protNow;
  logic                 allowed;
  fault_e               faultNow;

  assign vpnIn     = reqVaddr[ADDR_W-1:PAGE_BITS];
  assign vpnScaled = {{PAGE_BITS{1'b0}}, vpnIn} << ENTRY_SHIFT;

  // base register, sampled into the entry address when a request is taken
  always_ff @(posedge clk) begin
    if (!rstN)         baseQ <= '0;
    else if (ptBaseWe) baseQ <= ptBaseIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      offQ  <= '0;
      isWrQ <= 1'b0;
      isExQ <= 1'b0;
    end else if (stb.takeReq) begin
      addrQ <= baseQ + vpnScaled;
      offQ  <= reqVaddr[PAGE_BITS-1:0];
      isWrQ <= reqWrite;
      isExQ <= reqFetch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              entryQ <= '0;
    else if (stb.takeEntry) entryQ <= memRdata;
  end

  // permission decode
  assign protNow = prot_e'(entryQ[PROT_LSB+1:PROT_LSB]);

  always_comb begin
    case (protNow)
      PR_NONE: allowed = 1'b0;
      PR_RO:   allowed = !isWrQ && !isExQ;
      PR_RW:   allowed = !isExQ;
      PR_RWX:  allowed = 1'b1;
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!entryQ[VLD_BIT])  faultNow = FLT_ABSENT;
    else if (!allowed)     faultNow = FLT_PROT;
    else                   faultNow = FLT_NONE;
  end

  // usage-bit update
  always_comb begin
    newEntry = entryQ;
    newEntry[REF_BIT] = 1'b1;
    if (isWrQ) newEntry[MOD_BIT] = 1'b1;
  end

  assign chkWb    = (newEntry != entryQ);
  assign chkFault = (faultNow != FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= FLT_NONE;
      paddrQ <= '0;
    end else if (stb.takeResult) begin
      faultQ <= faultNow;
      paddrQ <= (faultNow == FLT_NONE) ? {entryQ[ADDR_W-1:PAGE_BITS], offQ} : '0;
    end
  end

  assign entryAddr = addrQ;
  assign rspPaddr  = paddrQ;
  assign rspFault  = faultQ;

endmodule

// File: rtl/pte_walker.sv
module pte_walker
  import pte_walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptBaseWe,
  input  logic [ADDR_W-1:0] ptBaseIn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [1:0]        rspFault,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata
);

  strobe_t stb;
  logic    chkFault, chkWb;

  pte_walk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memAck   (memAck),
    .chkFault (chkFault),
    .chkWb    (chkWb),
    .reqReady (reqReady),
    .stb      (stb)
  );

  pte_walk_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .PTE_BYTES (PTE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ptBaseWe  (ptBaseWe),
    .ptBaseIn  (ptBaseIn),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .reqFetch  (reqFetch),
    .memRdata  (memRdata),
    .entryAddr (memAddr),
    .newEntry  (memWdata),
    .chkFault  (chkFault),
    .chkWb     (chkWb),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault)
  );

  assign memReq   = stb.busRd | stb.busWr;
  assign memWe    = stb.busWr;
  assign rspValid = stb.rspOut;

endmodule

// File: rtl/pte_walker_chk.sv
module pte_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [1:0]        rspFault,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata
);

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R2

  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'b11)); // R3

  AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memWdata[1] && memWdata[0])); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || rspValid) |-> !reqReady); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspPaddr == '0)); // R12

endmodule

bind pte_walker pte_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pte_walker.sv
module sim_pte_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ptBaseWe = 1'b0;
  logic [31:0] ptBaseIn = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqFetch = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #2 clk = ~clk;

  pte_walker u0 (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: one-cycle acknowledge
  logic [31:0] mem [logic [31:0]];
  logic [31:0] lastRd = '0;
  int wrCnt = 0;

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr] = memWdata;
        wrCnt <= wrCnt + 1;
      end else begin
        lastRd   <= memAddr;
        memRdata <= mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      end
    end
  end

  // bench shadow of the table
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] curBase = '0;

  typedef struct packed {
    logic [31:0] paddr;
    logic [1:0]  fault;
    logic [31:0] rdAddr;
    logic        wb;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    acceptCyc = 0;
  int    lastWr = 0;

  function automatic logic [31:0] mkPte(logic [19:0] pfn, logic [1:0] prot,
                                        logic m, logic r, logic v);
    return {pfn, 7'b0, prot, m, r, v};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic putPte(logic [19:0] vpn, logic [31:0] e);
    logic [31:0] a;
    a = curBase + {10'b0, vpn, 2'b00};
    mem[a] = e;
    shadow[a] = e;
  endtask

  task automatic loadBase(logic [31:0] b);
    @(negedge clk);
    ptBaseWe = 1'b1;
    ptBaseIn = b;
    @(negedge clk);
    ptBaseWe = 1'b0;
    curBase = b;
  endtask

  // driver: predicts the result and pushes it to the scoreboard
  task automatic issue(string tag, logic [31:0] va, logic wr, logic ex);
    exp_t        it;
    logic [31:0] a, e, ne;
    logic [1:0]  pr;
    logic        ok;
    a  = curBase + {10'b0, va[31:12], 2'b00};
    e  = shadow.exists(a) ? shadow[a] : 32'h0;
    pr = e[4:3];
    ok = (pr == 2'b11) || (pr == 2'b10 && !ex) || (pr == 2'b01 && !ex && !wr);
    it.rdAddr = a;
    if (!e[0]) begin
      it.fault = 2'b01; it.paddr = '0; it.wb = 1'b0;
    end else if (!ok) begin
      it.fault = 2'b10; it.paddr = '0; it.wb = 1'b0;
    end else begin
      ne = e | 32'h2 | (wr ? 32'h4 : 32'h0);
      it.fault = 2'b00;
      it.paddr = {e[31:12], va[11:0]};
      it.wb = (ne != e);
      shadow[a] = ne;
    end
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    reqWrite = wr;
    reqFetch = ex;
    while (!reqReady) @(negedge clk);
    expQ.push_back(it);
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    acceptCyc = cyc;
    reqValid = 1'b0;
    check("R9", "reqReady while busy", {31'b0, reqReady}, 32'h0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      exp_t  it;
      string tg;
      if (expQ.size() == 0) begin
        check("R9", "unexpected response", 32'h1, 32'h0);
      end else begin
        it = expQ.pop_front();
        tg = tagQ.pop_front();
        check(tg, "fault", {30'b0, rspFault}, {30'b0, it.fault});
        check(tg, "paddr", rspPaddr, it.paddr);
        check("R2", "entry address", lastRd, it.rdAddr);
        check("R8", "writes", wrCnt - lastWr, it.wb ? 1 : 0);
        check("R10", "latency", cyc - acceptCyc, it.wb ? 5 : 3);
      end
      lastWr = wrCnt;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "reset reqReady", {31'b0, reqReady}, 32'h1);
    check("R9", "reset rspValid", {31'b0, rspValid}, 32'h0);
    check("R2", "reset memReq", {31'b0, memReq}, 32'h0);

    // R11: base resets to zero
    putPte(20'h00000, mkPte(20'h55555, 2'b10, 1'b0, 1'b1, 1'b1));
    issue("R11", 32'h0000_0ABC, 1'b0, 1'b0);

    loadBase(32'h0010_0000);
    // R1: worked example, first touch sets referenced
    putPte(20'h13325, mkPte(20'h03004, 2'b10, 1'b0, 1'b0, 1'b1));
    issue("R1", 32'h1332_5328, 1'b0, 1'b0);
    issue("R8", 32'h1332_5000, 1'b0, 1'b0);
    issue("R7", 32'h1332_5FFF, 1'b1, 1'b0);
    issue("R8", 32'h1332_5004, 1'b1, 1'b0);

    // R3: absent entry
    putPte(20'h00001, mkPte(20'h12345, 2'b11, 1'b0, 1'b0, 1'b0));
    issue("R3", 32'h0000_1010, 1'b0, 1'b0);
    issue("R3", 32'h0000_1020, 1'b1, 1'b0);

    // R4: read-only page
    putPte(20'h00002, mkPte(20'h0BEEF, 2'b01, 1'b0, 1'b0, 1'b1));
    issue("R4", 32'h0000_2100, 1'b1, 1'b0);
    issue("R4", 32'h0000_2104, 1'b0, 1'b0);

    // R6: no-access page
    putPte(20'h00003, mkPte(20'h0CAFE, 2'b00, 1'b0, 1'b0, 1'b1));
    issue("R6", 32'h0000_3000, 1'b0, 1'b0);

    // R5: fetch needs execute
    issue("R5", 32'h1332_5100, 1'b0, 1'b1);
    putPte(20'h00004, mkPte(20'h00777, 2'b11, 1'b0, 1'b0, 1'b1) | 32'h0000_0FE0);
    issue("R5", 32'h0000_4200, 1'b0, 1'b1);
    // R7: store keeps reserved bits
    issue("R7", 32'h0000_4204, 1'b1, 1'b0);

    // R11: new base
    loadBase(32'h0040_0000);
    putPte(20'h13325, mkPte(20'hABCDE, 2'b01, 1'b0, 1'b1, 1'b1));
    issue("R11", 32'h1332_5328, 1'b0, 1'b0);
    // R2: highest page
    putPte(20'hFFFFF, mkPte(20'hFEDCB, 2'b10, 1'b0, 1'b0, 1'b1));
    issue("R2", 32'hFFFF_FFFF, 1'b1, 1'b0);

    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    foreach (shadow[k]) begin
      check("R7", "table contents", mem.exists(k) ? mem[k] : 32'h0, shadow[k]);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule